// File: doc/BRIEF.md
# Disk Controller Data FIFO

This block is the byte buffer between the host/DMA side and the disk serializer of a floppy-style disk controller. It holds up to sixteen bytes. In write mode the host fills it and each disk byte-time strobe takes one byte out. In read mode each strobe puts one byte in from the disk and the host drains it. A registered service request tells the host or DMA engine when to act. The point at which the request asserts is set by a programmable threshold. That threshold gives the host a service window of roughly the threshold times the byte time.

Three phase pulses mark the command (parameter bytes), execution and result phases. The FIFO path works only during execution. The storage is flushed when a command or the execution phase starts, so stale bytes never reach the disk or the host.

A strobe that finds the FIFO empty in write mode, or full in read mode, ends the transfer and latches an error. After a write underrun the block supplies zero bytes until the current sector is complete, then pulses a CRC request. After a read overrun the host can still drain what was stored.

Top module: `dfifo_top`

## Requirements
- R1: Bytes leave the FIFO in the order they entered. The popped byte appears on `host_rdata` (read mode) or `disk_wdata` (write mode) in the cycle after the pop.
- R2: `fill_level` gives the stored byte count and never exceeds DEPTH. A push when full is ignored, and so is a host read when empty.
- R3: Outside the execution phase, host accesses and disk strobes leave the FIFO unchanged and `svc_req` stays low.
- R4: A `cmd_start` or `exec_start` pulse empties the FIFO in the following cycle.
- R5: In write mode (`dir_write`=1), `svc_req` sets when the free entries number at least the threshold, and clears when the FIFO is full. Between those two points it holds its value. A threshold of 0 acts as 1.
- R6: In read mode, `svc_req` sets when the stored bytes number at least the threshold, and clears when the FIFO is empty. Between those two points it holds its value.
- R7: In write mode, a disk strobe on an empty FIFO sets `underrun` and `terminated`. After that, host writes are ignored.
- R8: In read mode, a disk strobe on a full FIFO sets `overrun` and `terminated`. Later disk bytes are dropped, while host reads and `svc_req` keep working until the FIFO is empty.
- R9: The underrun strobe and each later strobe drive `disk_wdata` to 0x00 while `pad_active` is high. This continues until the sector byte count reaches `sect_len` (at least 1). That count covers every byte sent to the disk since execution began, data and zero bytes alike, and wraps at `sect_len`. The strobe that sends the last byte clears `pad_active` and produces a one-cycle `crc_req` pulse.
- R10: `terminated` stays set until `result_start`, `cmd_start` or `exec_start`. `overrun` and `underrun` stay set until `cmd_start` or `exec_start`.
- R11: After reset the block is idle: the FIFO is empty and all request and status outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Pulse: command phase begins |
| exec_start | input | 1 | Pulse: execution phase begins |
| result_start | input | 1 | Pulse: result phase begins |
| dir_write | input | 1 | 1 = host to disk, 0 = disk to host |
| thresh | input | $clog2(DEPTH) | Service threshold in bytes |
| sect_len | input | SECW | Bytes per sector |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | WIDTH | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | WIDTH | Byte popped for the host |
| disk_strobe | input | 1 | One pulse per disk byte time |
| disk_rdata | input | WIDTH | Byte from the disk (read mode) |
| disk_wdata | output | WIDTH | Byte to the disk (write mode) |
| svc_req | output | 1 | Service request to host/DMA |
| fill_level | output | $clog2(DEPTH+1) | Bytes stored |
| overrun | output | 1 | Read overrun latched |
| underrun | output | 1 | Write underrun latched |
| terminated | output | 1 | Transfer ended by an error |
| pad_active | output | 1 | Zero padding in progress |
| crc_req | output | 1 | Pulse: sector padded, append CRC |

## Verification
The hardest case to reach is an underrun that falls late in a sector, so that padding must carry across several strobes and stop exactly on the sector boundary. Another hard case is an underrun on the very last byte of a sector, where the CRC request must come at once and no padding cycle follows. Both are built on purpose by writing a counted number of bytes and then strobing one more time than there is data. Random sessions with random thresholds and sector lengths keep the disk side from starving, so they exercise the request hysteresis. The full-FIFO overrun case is driven on its own with threshold 15.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CMD    = 2'd1,
    PH_EXEC   = 2'd2,
    PH_RESULT = 2'd3
  } phase_e;
endpackage

// File: rtl/dfifo_ram.sv
module dfifo_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dfifo_req.sv
module dfifo_req #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       active,
  input  logic                       dir_write,
  input  logic [$clog2(DEPTH)-1:0]   thresh,
  input  logic [$clog2(DEPTH+1)-1:0] cnt_next,
  output logic                       svc_q
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] th_eff;
  logic [CW-1:0] free_next;

  always_comb begin
    th_eff    = (thresh == '0) ? CW'(1) : CW'(thresh);
    free_next = CW'(DEPTH) - cnt_next;
  end

  always_ff @(posedge clk) begin
    if (rst || clear || !active) begin
      svc_q <= 1'b0;
    end else if (dir_write) begin
      if (cnt_next == CW'(DEPTH))   svc_q <= 1'b0;
      else if (free_next >= th_eff) svc_q <= 1'b1;
    end else begin
      if (cnt_next == '0)           svc_q <= 1'b0;
      else if (cnt_next >= th_eff)  svc_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dfifo_pad.sv
module dfifo_pad #(
  parameter int SECW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            tick,
  input  logic            start,
  input  logic [SECW-1:0] sect_len,
  output logic            pad_q,
  output logic            crc_q
);
  logic [SECW-1:0] sec_q;
  logic            last;

  always_comb begin
    last = ({1'b0, sec_q} + (SECW+1)'(1)) >= {1'b0, sect_len};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sec_q <= '0;
      pad_q <= 1'b0;
      crc_q <= 1'b0;
    end else begin
      crc_q <= tick && (pad_q || start) && last;
      if (tick) sec_q <= last ? '0 : sec_q + SECW'(1);
      if (tick && last) pad_q <= 1'b0;
      else if (start)   pad_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dfifo_top.sv
module dfifo_top #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int SECW  = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_start,
  input  logic                       exec_start,
  input  logic                       result_start,
  input  logic                       dir_write,
  input  logic [$clog2(DEPTH)-1:0]   thresh,
  input  logic [SECW-1:0]            sect_len,
  input  logic                       host_wr,
  input  logic [WIDTH-1:0]           host_wdata,
  input  logic                       host_rd,
  output logic [WIDTH-1:0]           host_rdata,
  input  logic                       disk_strobe,
  input  logic [WIDTH-1:0]           disk_rdata,
  output logic [WIDTH-1:0]           disk_wdata,
  output logic                       svc_req,
  output logic [$clog2(DEPTH+1)-1:0] fill_level,
  output logic                       overrun,
  output logic                       underrun,
  output logic                       terminated,
  output logic                       pad_active,
  output logic                       crc_req
);
  import dfifo_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  phase_e         phase_q, phase_d;
  logic [AW-1:0]  wptr_q, rptr_q;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           term_q, term_d, ovr_q, und_q, zero_q;
  logic           is_exec, flush, empty, full, wr_side, rd_side;
  logic           push, pop, und_evt, ovr_evt, pad_strobe, byte_tick, active_d;
  logic [WIDTH-1:0] push_data, ram_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    is_exec    = (phase_q == PH_EXEC);
    flush      = cmd_start || exec_start;
    empty      = (cnt_q == '0);
    full       = (cnt_q == CW'(DEPTH));
    wr_side    = is_exec && dir_write;
    rd_side    = is_exec && !dir_write;
    push       = wr_side ? (host_wr && !term_q && !full)
                         : (rd_side && disk_strobe && !term_q && !full);
    pop        = wr_side ? (disk_strobe && !term_q && !empty)
                         : (rd_side && host_rd && !empty);
    push_data  = dir_write ? host_wdata : disk_rdata;
    und_evt    = wr_side && disk_strobe && !term_q && empty;
    ovr_evt    = rd_side && disk_strobe && !term_q && full;
    pad_strobe = wr_side && disk_strobe && pad_active;
    byte_tick  = (wr_side && pop) || und_evt || pad_strobe;
    cnt_d      = flush ? '0 : cnt_q + CW'(push) - CW'(pop);

    if (cmd_start)         phase_d = PH_CMD;
    else if (exec_start)   phase_d = PH_EXEC;
    else if (result_start) phase_d = PH_RESULT;
    else                   phase_d = phase_q;

    if (flush || result_start)  term_d = 1'b0;
    else if (und_evt || ovr_evt) term_d = 1'b1;
    else                        term_d = term_q;

    active_d = (phase_d == PH_EXEC) && (!dir_write || !term_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      term_q  <= 1'b0;
      ovr_q   <= 1'b0;
      und_q   <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      term_q  <= term_d;
      if (flush) begin
        wptr_q <= '0;
        rptr_q <= '0;
        ovr_q  <= 1'b0;
        und_q  <= 1'b0;
      end else begin
        if (push)    wptr_q <= ptr_inc(wptr_q);
        if (pop)     rptr_q <= ptr_inc(rptr_q);
        if (ovr_evt) ovr_q  <= 1'b1;
        if (und_evt) und_q  <= 1'b1;
      end
      if (und_evt || pad_strobe) zero_q <= 1'b1;
      else if (wr_side && pop)   zero_q <= 1'b0;
    end
  end

  dfifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) ram_i (
    .clk(clk), .we(push), .waddr(wptr_q), .wdata(push_data),
    .re(pop), .raddr(rptr_q), .rdata(ram_q)
  );

  dfifo_req #(.DEPTH(DEPTH)) req_i (
    .clk(clk), .rst(rst), .clear(flush), .active(active_d),
    .dir_write(dir_write), .thresh(thresh), .cnt_next(cnt_d), .svc_q(svc_req)
  );

  dfifo_pad #(.SECW(SECW)) pad_i (
    .clk(clk), .rst(rst), .clear(flush || result_start), .tick(byte_tick),
    .start(und_evt), .sect_len(sect_len), .pad_q(pad_active), .crc_q(crc_req)
  );

  assign host_rdata = ram_q;
  assign disk_wdata = zero_q ? '0 : ram_q;
  assign fill_level = cnt_q;
  assign overrun    = ovr_q;
  assign underrun   = und_q;
  assign terminated = term_q;
endmodule

// File: rtl/dfifo_chk.sv
module dfifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cmd_start,
  input logic                       exec_start,
  input logic [$clog2(DEPTH+1)-1:0] fill_level,
  input logic                       svc_req,
  input logic                       overrun,
  input logic                       underrun,
  input logic                       terminated,
  input logic                       pad_active,
  input logic                       crc_req
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill_level <= ($clog2(DEPTH+1))'(DEPTH)); // R2
  AST_FLUSH_ON_EXEC: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> fill_level == '0); // R4
  AST_CMD_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> !svc_req); // R3
  AST_PAD_NEEDS_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    pad_active |-> (terminated && underrun)); // R9
  AST_CRC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    crc_req |=> !crc_req); // R9
  AST_ERR_TERMINATES: assert property (@(posedge clk) disable iff (rst)
    ($rose(overrun) || $rose(underrun)) |-> terminated); // R10
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(overrun && underrun)); // R7
endmodule

bind dfifo_top dfifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .cmd_start(cmd_start), .exec_start(exec_start),
  .fill_level(fill_level), .svc_req(svc_req), .overrun(overrun),
  .underrun(underrun), .terminated(terminated), .pad_active(pad_active),
  .crc_req(crc_req)
);

// File: tb/dfifo_top_tb_top.sv
module dfifo_top_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 0, exec_start = 0, result_start = 0, dir_write = 0;
  logic [3:0] thresh = 0;
  logic [9:0] sect_len = 10'd8;
  logic host_wr = 0, host_rd = 0, disk_strobe = 0;
  logic [7:0] host_wdata = 0, disk_rdata = 0;
  logic [7:0] host_rdata, disk_wdata;
  logic svc_req, overrun, underrun, terminated, pad_active, crc_req;
  logic [4:0] fill_level;

  int checks = 0, fails = 0;

  // model state
  logic [7:0] mq[$];
  int  m_phase = 0;
  bit  m_term = 0, m_ovr = 0, m_und = 0, m_pad = 0, m_crc = 0, m_svc = 0;
  int  m_sec = 0;

  always #5 clk = ~clk;

  dfifo_top dut_i (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .exec_start(exec_start),
    .result_start(result_start), .dir_write(dir_write), .thresh(thresh),
    .sect_len(sect_len), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .disk_strobe(disk_strobe),
    .disk_rdata(disk_rdata), .disk_wdata(disk_wdata), .svc_req(svc_req),
    .fill_level(fill_level), .overrun(overrun), .underrun(underrun),
    .terminated(terminated), .pad_active(pad_active), .crc_req(crc_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit cs, es, rs, hw, input logic [7:0] hwd,
                      input bit hr, ds, input logic [7:0] drd);
    int  n, th, nphase;
    bit  ex, flush, push, pop, und_e, ovr_e, padt, tick, last, tnext, act;
    bit  dw_chk, hr_chk;
    logic [7:0] exp_b;
    @(negedge clk);
    cmd_start = cs; exec_start = es; result_start = rs;
    host_wr = hw; host_wdata = hwd; host_rd = hr; disk_strobe = ds; disk_rdata = drd;
    @(posedge clk); #1;
    n = mq.size(); ex = (m_phase == 2); flush = cs | es;
    push = ex && (dir_write ? (hw && !m_term) : (ds && !m_term)) && n < DEPTH;
    pop  = ex && (dir_write ? (ds && !m_term) : hr) && n > 0;
    und_e = ex && dir_write && ds && !m_term && n == 0;
    ovr_e = ex && !dir_write && ds && !m_term && n == DEPTH;
    padt  = ex && dir_write && ds && m_pad;
    tick  = (ex && dir_write && pop) || und_e || padt;
    last  = (m_sec + 1) >= int'(sect_len);
    dw_chk = 0; hr_chk = 0; exp_b = 8'h00;
    if (pop) begin
      exp_b = mq.pop_front();
      if (dir_write) dw_chk = 1; else hr_chk = 1;
    end
    if (und_e || padt) begin dw_chk = 1; exp_b = 8'h00; end
    if (push) mq.push_back(dir_write ? hwd : drd);
    if (flush) mq.delete();
    // pad and sector counter
    if (flush || rs) begin m_sec = 0; m_pad = 0; m_crc = 0; end
    else begin
      m_crc = tick && (m_pad || und_e) && last;
      if (tick && last) m_pad = 0; else if (und_e) m_pad = 1;
      if (tick) m_sec = last ? 0 : m_sec + 1;
    end
    nphase = cs ? 1 : es ? 2 : rs ? 3 : m_phase;
    tnext = (flush || rs) ? 0 : (und_e || ovr_e) ? 1 : m_term;
    if (flush) begin m_ovr = 0; m_und = 0; end
    else begin if (ovr_e) m_ovr = 1; if (und_e) m_und = 1; end
    act = (nphase == 2) && (!dir_write || !tnext);
    th = (thresh == 0) ? 1 : int'(thresh);
    n = mq.size();
    if (flush || !act) m_svc = 0;
    else if (dir_write) begin
      if (n == DEPTH) m_svc = 0; else if (DEPTH - n >= th) m_svc = 1;
    end else begin
      if (n == 0) m_svc = 0; else if (n >= th) m_svc = 1;
    end
    m_phase = nphase; m_term = tnext;
    // compare
    chk(es ? "R4 fill_level" : (m_phase != 2 ? "R3 fill_level" : "R2 fill_level"),
        int'(fill_level), n);
    chk(m_phase != 2 ? "R3 svc_req" : (dir_write ? "R5 svc_req" : "R6 svc_req"),
        int'(svc_req), int'(m_svc));
    chk("R10 terminated", int'(terminated), int'(m_term));
    chk("R8 overrun", int'(overrun), int'(m_ovr));
    chk("R7 underrun", int'(underrun), int'(m_und));
    chk("R9 pad_active", int'(pad_active), int'(m_pad));
    chk("R9 crc_req", int'(crc_req), int'(m_crc));
    if (dw_chk) chk((und_e || padt) ? "R9 disk_wdata" : "R1 disk_wdata",
                    int'(disk_wdata), int'(exp_b));
    if (hr_chk) chk("R1 host_rdata", int'(host_rdata), int'(exp_b));
  endtask

  task automatic idle_cycle();
    step(0, 0, 0, 0, 8'h00, 0, 0, 8'h00);
  endtask

  task automatic begin_exec(input bit dw, input int th, input int sl);
    @(negedge clk);
    dir_write = dw; thresh = 4'(th); sect_len = 10'(sl);
    step(1, 0, 0, 0, 8'h00, 0, 0, 8'h00);
    step(0, 1, 0, 0, 8'h00, 0, 0, 8'h00);
  endtask

  task automatic end_exec();
    step(0, 0, 1, 0, 8'h00, 0, 0, 8'h00);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R11 reset state
    chk("R11 fill_level", int'(fill_level), 0);
    chk("R11 svc_req", int'(svc_req), 0);
    chk("R11 terminated", int'(terminated), 0);
    chk("R11 pad_active", int'(pad_active), 0);
    chk("R11 crc_req", int'(crc_req), 0);
    chk("R11 flags", int'(overrun) + int'(underrun), 0);

    // R3: idle and command phase ignore data traffic
    dir_write = 1;
    step(0, 0, 0, 1, 8'h11, 0, 1, 8'h00);
    step(1, 0, 0, 1, 8'h22, 1, 1, 8'h33);
    step(0, 0, 0, 1, 8'h44, 0, 0, 8'h00);

    // R4: flush on re-entry into execution
    begin_exec(1, 4, 16);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 8'(i + 8'h50), 0, 0, 8'h00);
    step(0, 1, 0, 0, 8'h00, 0, 0, 8'h00);

    // R2/R5: overfill in write mode
    for (int i = 0; i < 18; i++) step(0, 0, 0, 1, 8'(8'hA0 + i), 0, 0, 8'h00);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 8'h00, 0, 1, 8'h00);
    end_exec();

    // random sessions, both directions, random threshold and sector length
    for (int s = 0; s < 8; s++) begin
      begin_exec(s[0], int'($urandom % 16), 4 + int'($urandom % 20));
      for (int c = 0; c < 150; c++) begin
        bit hw, hr, ds;
        hw = ($urandom % 2) == 0;
        hr = ($urandom % 2) == 0;
        ds = ($urandom % 3) == 0;
        if (dir_write && mq.size() == 0) ds = 0;
        if (!dir_write && mq.size() == DEPTH) ds = 0;
        step(0, 0, 0, hw, 8'($urandom), hr, ds, 8'($urandom));
      end
      end_exec();
    end

    // R7/R9: underrun mid-sector, padding to sector end
    begin_exec(1, 2, 6);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 8'(8'hC1 + i), 0, 0, 8'h00);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 8'h00, 0, 1, 8'h00);
    step(0, 0, 0, 0, 8'h00, 0, 1, 8'h00);     // underrun, zero byte
    step(0, 0, 0, 1, 8'h77, 0, 0, 8'h00);     // R7 host write ignored
    step(0, 0, 0, 0, 8'h00, 0, 1, 8'h00);
    step(0, 0, 0, 0, 8'h00, 0, 1, 8'h00);     // last byte, crc pulse
    step(0, 0, 0, 0, 8'h00, 0, 1, 8'h00);     // ignored after padding
    idle_cycle();
    end_exec();                               // R10 terminated clears
    idle_cycle();

    // R9: underrun on the sector's last byte, crc at once
    begin_exec(1, 1, 4);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 8'(8'hE1 + i), 0, 0, 8'h00);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 8'h00, 0, 1, 8'h00);
    idle_cycle();
    end_exec();

    // R8: read overrun, host drains remaining bytes
    begin_exec(0, 15, 8);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 8'h00, 0, 1, 8'(8'h30 + i));
    step(0, 0, 0, 0, 8'h00, 0, 1, 8'hFF);     // overrun
    step(0, 0, 0, 0, 8'h00, 0, 1, 8'hFE);     // dropped
    for (int i = 0; i < 17; i++) step(0, 0, 0, 0, 8'h00, 1, 0, 8'h00);
    end_exec();
    idle_cycle();
    step(1, 0, 0, 0, 8'h00, 0, 0, 8'h00);     // R10 flags clear on command

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule